// File: doc/BRIEF.md
# Privileged Handler Entry Sequencer

This block moves a processor core out of normal execution and into privileged handler mode. A requester offers an entry through a valid/ready handshake. Each entry carries a two-bit reason code, a vector operand, the program counter of the faulting instruction, an arithmetic flag and a set of arithmetic summary bits. Once the block accepts the entry, it commits every architectural change on one clock edge. The program counter moves to the handler entry point with bit 0 set to mark handler mode. The exception address register takes the faulting PC. The interrupt priority level goes to 7 and the mode goes to kernel, which masks interrupts. The shadow register enable is set for explicit handler calls only. The arithmetic summary is updated when the entry is an arithmetic trap.

On the same edge, the previous PC, priority level, mode and shadow enable are copied into a context snapshot. The snapshot is taken from values that this entry has not yet touched. In the cycle after the commit, the block raises a one-cycle pipeline flush and holds ready low, so a second entry cannot overlap the flush.

Top module: `priv_entry_seq`

## Requirements
- R1: After reset the block shows the following state. ready=1, flush=0, pc=RESET_PC (default 0x2000_0000), exc_addr=0, ipl=0, mode=2'b11 (user), shadow_en=0, exc_sum=0, and the snapshot outputs are 0.
- R2: Reason codes are 2'b00 handler call, 2'b01 fault, 2'b10 trap and 2'b11 interrupt. For the fault, trap and interrupt reasons, pc takes the supplied vector with bits 1:0 replaced by 2'b01.
- R3: For a handler call the code is vector[7:0], and pc is handler_base + region + code[6:0]*64 with bits 1:0 replaced by 2'b01. The region is 0x1000 when code bit 7 is 0 and 0x2000 when it is 1. Vector bits above bit 7 have no effect.
- R4: Every committed entry loads exc_addr with req_fault_pc.
- R5: Every committed entry sets ipl to 7 and mode to 2'b00 (kernel).
- R6: shadow_en becomes 1 after a handler call and 0 after any other reason.
- R7: When the reason is trap and req_arith is 1, exc_sum becomes exc_sum OR req_sum_bits. Any other entry leaves exc_sum unchanged.
- R8: Each entry loads ctx_pc, ctx_ipl, ctx_mode and ctx_shadow with the values that pc, ipl, mode and shadow_en held just before that entry.
- R9: An entry is accepted on a clock edge where req_valid and req_ready are both 1. All its state is visible in the following cycle. In that same cycle flush is 1 for exactly one cycle and req_ready is 0.
- R10: When no entry is accepted, including while req_valid is held during the cycle with ready low, pc, exc_addr and exc_sum stay unchanged and no flush occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Entry request offered |
| req_ready | output | 1 | Block can accept an entry this cycle |
| req_reason | input | 2 | Reason code |
| req_vector | input | XLEN | Entry vector, or handler call code in bits 7:0 |
| req_fault_pc | input | XLEN | PC of the faulting instruction |
| req_arith | input | 1 | Trap is arithmetic |
| req_sum_bits | input | SUM_W | Arithmetic summary bits to merge |
| handler_base | input | XLEN | Handler base address |
| flush | output | 1 | One-cycle pipeline flush pulse |
| pc | output | XLEN | Current program counter |
| exc_addr | output | XLEN | Exception address register |
| ipl | output | IPL_W | Interrupt priority level |
| mode | output | 2 | Current mode |
| shadow_en | output | 1 | Shadow register enable |
| exc_sum | output | SUM_W | Exception summary |
| ctx_pc | output | XLEN | Snapshot of the previous PC |
| ctx_ipl | output | IPL_W | Snapshot of the previous priority level |
| ctx_mode | output | 2 | Snapshot of the previous mode |
| ctx_shadow | output | 1 | Snapshot of the previous shadow enable |

## Verification
The properties sample the request fields on the accepting edge only, so they do not need the fields to be held while ready is low. They do assume that every request input has a known value whenever req_valid is high, and that handler_base changes only between requests. The bench drives all fields together at the falling edge and holds them until the request is accepted. It sets handler_base once, before the first request, and never changes it afterwards.

// File: rtl/priv_entry_pkg.sv
package priv_entry_pkg;
  typedef enum logic [1:0] {
    RSN_CALL  = 2'b00,
    RSN_FAULT = 2'b01,
    RSN_TRAP  = 2'b10,
    RSN_INTR  = 2'b11
  } reason_e;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_EXEC   = 2'b01,
    MODE_SUPER  = 2'b10,
    MODE_USER   = 2'b11
  } mode_e;
endpackage

// File: rtl/entry_vector_calc.sv
module entry_vector_calc
  import priv_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SLOT_SHIFT = 6,
  parameter logic [XLEN-1:0] LOW_OFS  = 'h1000,
  parameter logic [XLEN-1:0] HIGH_OFS = 'h2000
) (
  input  logic [1:0]      reason,
  input  logic [XLEN-1:0] vector,
  input  logic [XLEN-1:0] base,
  output logic [XLEN-1:0] entry_pc,
  output logic            is_call
);
  localparam int unsigned IDX_W = CODE_W - 1;

  // Handler call target: base + region + slot index * slot size.
  function automatic logic [XLEN-1:0] call_target(
    input logic [XLEN-1:0]   b,
    input logic [CODE_W-1:0] code
  );
    logic [XLEN-1:0] region;
    logic [XLEN-1:0] slot;
    region = code[CODE_W-1] ? HIGH_OFS : LOW_OFS;
    slot   = XLEN'(code[IDX_W-1:0]) << SLOT_SHIFT;
    return b + region + slot;
  endfunction

  // Clear the alignment bits and set the handler-mode marker in bit 0.
  function automatic logic [XLEN-1:0] mark_handler(input logic [XLEN-1:0] t);
    return {t[XLEN-1:2], 2'b01};
  endfunction

  logic [XLEN-1:0] target;

  always_comb begin
    is_call = (reason_e'(reason) == RSN_CALL);
    target  = is_call ? call_target(base, vector[CODE_W-1:0]) : vector;
    entry_pc = mark_handler(target);
  end
endmodule

// File: rtl/entry_handshake.sv
module entry_handshake #(
  parameter int unsigned COOL_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic fire,
  output logic flush
);
  localparam int unsigned CNT_W = (COOL_CYC < 1) ? 1 : $clog2(COOL_CYC + 1);

  logic [CNT_W-1:0] cool_cnt;
  logic             flush_q;

  assign req_ready = (cool_cnt == '0);
  assign fire      = req_valid && req_ready;
  assign flush     = flush_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cool_cnt <= '0;
      flush_q  <= 1'b0;
    end else begin
      flush_q <= fire;
      if (fire)
        cool_cnt <= CNT_W'(COOL_CYC);
      else if (cool_cnt != '0)
        cool_cnt <= cool_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/entry_state_regs.sv
module entry_state_regs
  import priv_entry_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IPL_W = 5,
  parameter int unsigned SUM_W = 7,
  parameter logic [XLEN-1:0] RESET_PC = 'h2000_0000,
  parameter int unsigned HANDLER_IPL = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [XLEN-1:0]  entry_pc,
  input  logic [XLEN-1:0]  fault_pc,
  input  logic             is_call,
  input  logic             sum_upd,
  input  logic [SUM_W-1:0] sum_bits,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  exc_addr,
  output logic [IPL_W-1:0] ipl,
  output logic [1:0]       mode,
  output logic             shadow_en,
  output logic [SUM_W-1:0] exc_sum,
  output logic [XLEN-1:0]  ctx_pc,
  output logic [IPL_W-1:0] ctx_ipl,
  output logic [1:0]       ctx_mode,
  output logic             ctx_shadow
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc         <= RESET_PC;
      exc_addr   <= '0;
      ipl        <= '0;
      mode       <= MODE_USER;
      shadow_en  <= 1'b0;
      exc_sum    <= '0;
      ctx_pc     <= '0;
      ctx_ipl    <= '0;
      ctx_mode   <= '0;
      ctx_shadow <= 1'b0;
    end else if (commit) begin
      ctx_pc     <= pc;
      ctx_ipl    <= ipl;
      ctx_mode   <= mode;
      ctx_shadow <= shadow_en;
      pc         <= entry_pc;
      exc_addr   <= fault_pc;
      ipl        <= IPL_W'(HANDLER_IPL);
      mode       <= MODE_KERNEL;
      shadow_en  <= is_call;
      if (sum_upd)
        exc_sum <= exc_sum | sum_bits;
    end
  end
endmodule

// File: rtl/priv_entry_seq.sv
module priv_entry_seq
  import priv_entry_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned IPL_W      = 5,
  parameter int unsigned SUM_W      = 7,
  parameter int unsigned CODE_W     = 8,
  parameter int unsigned SLOT_SHIFT = 6,
  parameter int unsigned COOL_CYC   = 1,
  parameter logic [XLEN-1:0] RESET_PC = 'h2000_0000,
  parameter logic [XLEN-1:0] LOW_OFS  = 'h1000,
  parameter logic [XLEN-1:0] HIGH_OFS = 'h2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_reason,
  input  logic [XLEN-1:0]  req_vector,
  input  logic [XLEN-1:0]  req_fault_pc,
  input  logic             req_arith,
  input  logic [SUM_W-1:0] req_sum_bits,
  input  logic [XLEN-1:0]  handler_base,
  output logic             flush,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  exc_addr,
  output logic [IPL_W-1:0] ipl,
  output logic [1:0]       mode,
  output logic             shadow_en,
  output logic [SUM_W-1:0] exc_sum,
  output logic [XLEN-1:0]  ctx_pc,
  output logic [IPL_W-1:0] ctx_ipl,
  output logic [1:0]       ctx_mode,
  output logic             ctx_shadow
);
  // Named internal events
  logic            fire;
  logic            is_call;
  logic            sum_upd;
  logic [XLEN-1:0] entry_pc;

  assign sum_upd = (reason_e'(req_reason) == RSN_TRAP) && req_arith;

  entry_handshake #(.COOL_CYC(COOL_CYC)) u_hs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_ready(req_ready), .fire(fire), .flush(flush)
  );

  entry_vector_calc #(
    .XLEN(XLEN), .CODE_W(CODE_W), .SLOT_SHIFT(SLOT_SHIFT),
    .LOW_OFS(LOW_OFS), .HIGH_OFS(HIGH_OFS)
  ) u_vec (
    .reason(req_reason), .vector(req_vector), .base(handler_base),
    .entry_pc(entry_pc), .is_call(is_call)
  );

  entry_state_regs #(
    .XLEN(XLEN), .IPL_W(IPL_W), .SUM_W(SUM_W), .RESET_PC(RESET_PC)
  ) u_st (
    .clk(clk), .rst_n(rst_n), .commit(fire), .entry_pc(entry_pc),
    .fault_pc(req_fault_pc), .is_call(is_call), .sum_upd(sum_upd),
    .sum_bits(req_sum_bits), .pc(pc), .exc_addr(exc_addr), .ipl(ipl),
    .mode(mode), .shadow_en(shadow_en), .exc_sum(exc_sum),
    .ctx_pc(ctx_pc), .ctx_ipl(ctx_ipl), .ctx_mode(ctx_mode),
    .ctx_shadow(ctx_shadow)
  );
endmodule

// File: rtl/priv_entry_seq_chk.sv
module priv_entry_seq_chk #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IPL_W = 5,
  parameter int unsigned SUM_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_reason,
  input logic             req_arith,
  input logic [XLEN-1:0]  req_fault_pc,
  input logic             fire,
  input logic             flush,
  input logic [XLEN-1:0]  pc,
  input logic [XLEN-1:0]  exc_addr,
  input logic [IPL_W-1:0] ipl,
  input logic [1:0]       mode,
  input logic             shadow_en,
  input logic [SUM_W-1:0] exc_sum,
  input logic [XLEN-1:0]  ctx_pc,
  input logic [IPL_W-1:0] ctx_ipl
);
  // R9
  accept_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (flush && !req_ready));

  // R9
  flush_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(req_valid && req_ready));

  // R5
  handler_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (pc[0] && ipl == IPL_W'(7) && mode == 2'b00));

  // R4
  exc_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (exc_addr == $past(req_fault_pc)));

  // R8
  snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (ctx_pc == $past(pc) && ctx_ipl == $past(ipl)));

  // R6
  shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (shadow_en == ($past(req_reason) == 2'b00)));

  // R7
  sum_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(req_reason == 2'b10 && req_arith)) |=> $stable(exc_sum));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(pc) && $stable(exc_addr) && $stable(exc_sum) && !flush));
endmodule

bind priv_entry_seq priv_entry_seq_chk #(
  .XLEN(XLEN), .IPL_W(IPL_W), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_reason(req_reason), .req_arith(req_arith), .req_fault_pc(req_fault_pc),
  .fire(fire), .flush(flush), .pc(pc), .exc_addr(exc_addr), .ipl(ipl),
  .mode(mode), .shadow_en(shadow_en), .exc_sum(exc_sum), .ctx_pc(ctx_pc),
  .ctx_ipl(ctx_ipl)
);

// File: tb/test_priv_entry_seq.sv
module test_priv_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_reason = '0;
  logic [63:0] req_vector = '0;
  logic [63:0] req_fault_pc = '0;
  logic        req_arith = 1'b0;
  logic [6:0]  req_sum_bits = '0;
  logic [63:0] handler_base = 64'h0000_0000_0010_0000;
  logic        flush;
  logic [63:0] pc, exc_addr, ctx_pc;
  logic [4:0]  ipl, ctx_ipl;
  logic [1:0]  mode, ctx_mode;
  logic        shadow_en, ctx_shadow;
  logic [6:0]  exc_sum;

  always #2.5 clk = ~clk;

  priv_entry_seq i_priv_entry_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_reason(req_reason), .req_vector(req_vector), .req_fault_pc(req_fault_pc),
    .req_arith(req_arith), .req_sum_bits(req_sum_bits), .handler_base(handler_base),
    .flush(flush), .pc(pc), .exc_addr(exc_addr), .ipl(ipl), .mode(mode),
    .shadow_en(shadow_en), .exc_sum(exc_sum), .ctx_pc(ctx_pc), .ctx_ipl(ctx_ipl),
    .ctx_mode(ctx_mode), .ctx_shadow(ctx_shadow)
  );

  typedef struct {
    string       tag;
    logic [63:0] pc, exc_addr, ctx_pc;
    logic [4:0]  ipl, ctx_ipl;
    logic [1:0]  mode, ctx_mode;
    logic        shadow, ctx_shadow;
    logic [6:0]  sum;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state kept by the bench
  logic [63:0] m_pc = 64'h2000_0000;
  logic [63:0] m_exc = '0;
  logic [4:0]  m_ipl = '0;
  logic [1:0]  m_mode = 2'b11;
  logic        m_shadow = 1'b0;
  logic [6:0]  m_sum = '0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // Driver: caller is at a falling edge; returns at the falling edge after acceptance.
  task automatic send(string tag, logic [1:0] rsn, logic [63:0] vec,
                      logic [63:0] fpc, logic arith, logic [6:0] bits);
    exp_t e;
    logic [63:0] tgt;
    req_valid = 1'b1; req_reason = rsn; req_vector = vec;
    req_fault_pc = fpc; req_arith = arith; req_sum_bits = bits;
    while (!req_ready) @(negedge clk);
    if (rsn == 2'b00)
      tgt = handler_base + (vec[7] ? 64'd8192 : 64'd4096) + 64'(vec[6:0]) * 64'd64;
    else
      tgt = vec;
    e.tag = tag;
    e.ctx_pc = m_pc; e.ctx_ipl = m_ipl; e.ctx_mode = m_mode; e.ctx_shadow = m_shadow;
    m_pc = (tgt & ~64'h3) | 64'h1;
    m_exc = fpc; m_ipl = 5'd7; m_mode = 2'b00; m_shadow = (rsn == 2'b00);
    if (rsn == 2'b10 && arith) m_sum = m_sum | bits;
    e.pc = m_pc; e.exc_addr = m_exc; e.ipl = m_ipl; e.mode = m_mode;
    e.shadow = m_shadow; e.sum = m_sum;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 1'b0;
    req_reason = 2'b10; req_arith = 1'b1; req_sum_bits = 7'h7F;
    req_vector = 64'hDEAD_BEEF; req_fault_pc = 64'hBAD0;
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && flush) begin
        chk("R9", "ready low during flush", 64'(req_ready), 64'd0);
        if (q.size() == 0) begin
          chk("R10", "unexpected flush", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, "/R2R3"}, "pc", pc, e.pc);
          chk({e.tag, "/R4"}, "exc_addr", exc_addr, e.exc_addr);
          chk({e.tag, "/R5"}, "ipl", 64'(ipl), 64'(e.ipl));
          chk({e.tag, "/R5"}, "mode", 64'(mode), 64'(e.mode));
          chk({e.tag, "/R6"}, "shadow_en", 64'(shadow_en), 64'(e.shadow));
          chk({e.tag, "/R7"}, "exc_sum", 64'(exc_sum), 64'(e.sum));
          chk({e.tag, "/R8"}, "ctx_pc", ctx_pc, e.ctx_pc);
          chk({e.tag, "/R8"}, "ctx_ipl", 64'(ctx_ipl), 64'(e.ctx_ipl));
          chk({e.tag, "/R8"}, "ctx_mode", 64'(ctx_mode), 64'(e.ctx_mode));
          chk({e.tag, "/R8"}, "ctx_shadow", 64'(ctx_shadow), 64'(e.ctx_shadow));
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "ready", 64'(req_ready), 64'd1);
    chk("R1", "flush", 64'(flush), 64'd0);
    chk("R1", "pc", pc, 64'h2000_0000);
    chk("R1", "exc_addr", exc_addr, 64'd0);
    chk("R1", "ipl", 64'(ipl), 64'd0);
    chk("R1", "mode", 64'(mode), 64'd3);
    chk("R1", "shadow_en", 64'(shadow_en), 64'd0);
    chk("R1", "exc_sum", 64'(exc_sum), 64'd0);
    chk("R1", "ctx_pc", ctx_pc, 64'd0);
    idle(2);

    // R2 fault with misaligned vector
    send("R2 fault", 2'b01, 64'h0000_0000_0000_4403, 64'h1234_5670, 1'b0, 7'h00);
    idle(1);
    // R3 lower region, upper vector bits ignored
    send("R3 call low", 2'b00, 64'hFFFF_0000_0000_0105, 64'h1000_0004, 1'b0, 7'h00);
    // R10 back-to-back: held valid during not-ready cycle
    send("R3 call high", 2'b00, 64'h0000_0000_0000_0083, 64'h1000_0008, 1'b0, 7'h00);
    send("R3 call top of low", 2'b00, 64'h0000_0000_0000_007F, 64'h1000_000C, 1'b0, 7'h00);
    send("R3 call top of high", 2'b00, 64'h0000_0000_0000_00FF, 64'h1000_0010, 1'b0, 7'h00);
    idle(2);
    // R7 arithmetic traps accumulate
    send("R7 arith trap a", 2'b10, 64'h0000_0000_0000_8000, 64'h2222_0000, 1'b1, 7'h05);
    send("R7 arith trap b", 2'b10, 64'h0000_0000_0000_8100, 64'h2222_0004, 1'b1, 7'h42);
    send("R7 plain trap", 2'b10, 64'h0000_0000_0000_8202, 64'h2222_0008, 1'b0, 7'h7F);
    send("R7 fault with bits", 2'b01, 64'h0000_0000_0000_8300, 64'h2222_000C, 1'b1, 7'h7F);
    // R2 interrupt after call: shadow clears
    send("R3 call", 2'b00, 64'h0000_0000_0000_0001, 64'h3333_0000, 1'b0, 7'h00);
    send("R6 interrupt", 2'b11, 64'hFFFF_FFFF_FFFF_F001, 64'h3333_0004, 1'b0, 7'h00);
    idle(1);

    // R10 idle: garbage fields with valid low leave state alone
    idle(6);
    chk("R10", "pc held", pc, m_pc);
    chk("R10", "exc_addr held", exc_addr, m_exc);
    chk("R10", "exc_sum held", 64'(exc_sum), 64'(m_sum));
    chk("R10", "no flush", 64'(flush), 64'd0);
    chk("R9", "queue drained", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule